// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block models a single-port synchronous static memory with burst addressing. All control inputs are sampled on the rising clock edge. There are two active-low address strobes: a processor-side strobe and a controller-side strobe. There are also three chip enables, an active-low burst advance, an active-low write-all control, an active-low byte-write enable and one active-low select per byte lane.

A strobe accepted while the chip is selected loads the address register and a two-bit burst counter. Later advance cycles step through the aligned group of four words, in linear or interleaved order. A strobe accepted while the chip is not selected ends the burst.

Read data is registered. Instead of tristate pins, the block has separate write-data and read-data ports and a read-data-valid output. That output is gated by an asynchronous active-low output enable. It is also held low for the first read clock after the chip has been deselected.

Top module: `sbs_core`

## Requirements
- R1: The chip is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. An accepted strobe while not selected is a deselect: it ends the burst, and `rdata_en` is 0 after that edge and stays 0 until a new address is loaded.
- R2: `as_proc_n` is ignored while `cs0_n` is 1. It neither loads nor deselects, and a burst in progress keeps advancing on `adv_n`=0.
- R3: An accepted strobe while selected captures `addr`. In a read, `rdata` shows the word at that address after the same edge, so one clock later.
- R4: With `burst_ilv`=0, each edge with `adv_n`=0 during a burst moves to word offset (start+k) mod 4, counting k advances since the load. `addr` bits 18..2 are held for the whole burst.
- R5: With `burst_ilv`=1, the offset after k advances is start XOR k.
- R6: `adv_n` has no effect on an edge that loads an address. With `adv_n`=1 and no strobe, the burst address is held and the same word is read again.
- R7: `wr_all_n`=0 writes every lane (lane i = bits 9i+8..9i of an 18-bit word), whatever `wr_byte_n` and `lane_sel_n` hold.
- R8: With `wr_all_n`=1, lane i is written only when `wr_byte_n`=0 and `lane_sel_n[i]`=0. With no lane written, the cycle is a read.
- R9: An edge that loads through `as_proc_n` is always a read. The write controls are ignored on that edge.
- R10: `rdata_en` follows `out_en_n` without waiting for a clock: 0 whenever `out_en_n`=1.
- R11: The first read after reset or after a deselect has `rdata_en`=0 for its one output cycle. Later reads of that burst are driven normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 19 | Word address; low ADDR_MEM bits index the array (default 64 words, upper bits alias) |
| as_proc_n | input | 1 | Processor-side address strobe, active low, read-only start |
| as_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs0_n | input | 1 | Chip enable, active low |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Write every lane, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | 2 | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| burst_ilv | input | 1 | 0 linear burst order, 1 interleaved |
| wdata | input | 18 | Write data, two 9-bit lanes |
| rdata | output | 18 | Registered read data |
| rdata_en | output | 1 | Read data is driven |

## Verification
Several decode paths can meet on one edge. An advance arriving together with an accepted strobe must lose to the load. An advance arriving together with a processor strobe that the first enable masks must still step the burst. The bench drives both coincidences on purpose and reads back the word reached on the next clock. A deselect followed by a fresh load is also driven, to show that the mask hides the first returned word while the data itself is already correct.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef struct packed {
    logic load;        // accepted strobe while selected
    logic desel;       // accepted strobe while not selected
    logic proc_start;  // load came through the processor strobe
  } sbs_ev_t;

  // word offset inside the aligned group of four after cnt advances
  function automatic logic [1:0] burst_off(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/sbs_select.sv
module sbs_select
  import sbs_pkg::*;
(
  input  logic    as_proc_n,
  input  logic    as_ctl_n,
  input  logic    cs0_n,
  input  logic    cs1,
  input  logic    cs2_n,
  output sbs_ev_t ev
);
  logic sel, proc_take, ctl_take, strobe;

  assign sel       = ~cs0_n & cs1 & ~cs2_n;
  assign proc_take = ~as_proc_n & ~cs0_n;
  assign ctl_take  = ~as_ctl_n;
  assign strobe    = proc_take | ctl_take;

  assign ev.load       = strobe & sel;
  assign ev.desel      = strobe & ~sel;
  assign ev.proc_start = proc_take & sel;

  // R2
  always_comb begin
    if (cs0_n && as_ctl_n) begin
      proc_masked_chk: assert (!ev.load && !ev.desel);
    end
  end
endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  sbs_ev_t           ev,
  input  logic              adv_n,
  input  logic              ilv,
  output logic              acc,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              adv_ev
);
  logic [ADDR_W-1:0] cur_q;
  logic [1:0]        start_q, cnt_q, cnt_nx;
  logic              active_q;

  assign adv_ev   = active_q & ~adv_n & ~ev.load & ~ev.desel;
  assign cnt_nx   = cnt_q + 2'd1;
  assign acc      = ev.load | (active_q & ~ev.desel);
  assign acc_addr = ev.load ? addr :
                    adv_ev  ? {cur_q[ADDR_W-1:2], burst_off(start_q, cnt_nx, ilv)} :
                              cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q    <= '0;
      start_q  <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (ev.load) begin
      cur_q    <= addr;
      start_q  <= addr[1:0];
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (ev.desel) begin
      active_q <= 1'b0;
    end else if (adv_ev) begin
      cur_q <= acc_addr;
      cnt_q <= cnt_nx;
    end
  end

  // R3
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.load |=> (cur_q == $past(addr)) && active_q);

  // R4
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |=> cur_q[ADDR_W-1:2] == $past(cur_q[ADDR_W-1:2]));

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && adv_n && !ev.load && !ev.desel) |=> $stable(cur_q));
endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int MEM_AW = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [MEM_AW-1:0] widx,
  input  logic              proc_start,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rd_ev
);
  logic [DW-1:0]    mem [DEPTH];
  logic [LANES-1:0] lane_we;
  logic             wr_ev, wr_ok;

  assign wr_ok = acc & ~proc_start;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = wr_ok & (~wr_all_n | (~wr_byte_n & ~lane_sel_n[i]));
  end

  assign wr_ev = |lane_we;
  assign rd_ev = acc & ~wr_ev;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (lane_we[i]) mem[widx][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
    end
    if (rd_ev) rdata <= mem[widx];
  end

  // R7
  all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !wr_all_n) |=> mem[$past(widx)] == $past(wdata));

  // R8
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wr_all_n && wr_byte_n) |=> mem[$past(widx)] == $past(mem[widx]));
endmodule

// File: rtl/sbs_core.sv
module sbs_core
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int MEM_AW = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              as_proc_n,
  input  logic              as_ctl_n,
  input  logic              adv_n,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              out_en_n,
  input  logic              burst_ilv,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rdata_en
);
  sbs_ev_t           ev;
  logic              acc, adv_ev, rd_ev;
  logic [ADDR_W-1:0] acc_addr;
  logic              dsl_q, rv_q, mask_q;

  sbs_select u_sel (
    .as_proc_n(as_proc_n), .as_ctl_n(as_ctl_n),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .ev(ev)
  );

  sbs_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ev(ev), .adv_n(adv_n),
    .ilv(burst_ilv), .acc(acc), .acc_addr(acc_addr), .adv_ev(adv_ev)
  );

  sbs_store #(.MEM_AW(MEM_AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .acc(acc), .widx(acc_addr[MEM_AW-1:0]),
    .proc_start(ev.proc_start), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_sel_n(lane_sel_n), .wdata(wdata), .rdata(rdata), .rd_ev(rd_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsl_q  <= 1'b1;
      rv_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      rv_q   <= rd_ev;
      mask_q <= rd_ev & dsl_q;
      if (ev.load)       dsl_q <= 1'b0;
      else if (ev.desel) dsl_q <= 1'b1;
    end
  end

  assign rdata_en = rv_q & ~mask_q & ~out_en_n;

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev.desel |=> !rdata_en);

  // R11
  first_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && dsl_q) |=> !rdata_en);

  // R4
  adv_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_ev |-> acc);
endmodule

// File: tb/tb_sbs_core.sv
module tb_sbs_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [18:0] addr;
  logic        as_proc_n, as_ctl_n, adv_n, cs0_n, cs1, cs2_n;
  logic        wr_all_n, wr_byte_n, out_en_n, burst_ilv;
  logic [1:0]  lane_sel_n;
  logic [17:0] wdata, rdata;
  logic        rdata_en;

  int checks = 0;
  int errors = 0;
  logic [17:0] ref_mem [0:63];

  sbs_core dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .as_proc_n(as_proc_n),
    .as_ctl_n(as_ctl_n), .adv_n(adv_n), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .burst_ilv(burst_ilv),
    .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    as_proc_n = 1; as_ctl_n = 1; adv_n = 1;
    cs0_n = 0; cs1 = 1; cs2_n = 0;
    wr_all_n = 1; wr_byte_n = 1; lane_sel_n = 2'b11;
  endtask

  function automatic logic [17:0] pat(input int a);
    return 18'((a * 18'h0A5B) ^ 18'h2C3);
  endfunction

  task automatic ctl_write(input int a, input logic [17:0] d);
    idle(); as_ctl_n = 0; addr = 19'(a); wr_all_n = 0; wdata = d;
    tick();
    idle();
    ref_mem[a] = d;
  endtask

  task automatic ctl_read(input int a);
    idle(); as_ctl_n = 0; addr = 19'(a);
    tick();
    idle();
  endtask

  task automatic t_reset();
    chk("R11 reset rdata_en", 32'(rdata_en), 32'd0);
  endtask

  task automatic t_fill();
    for (int a = 32'h20; a < 32'h28; a++) ctl_write(a, pat(a));
    ctl_write(32'h30, 18'h0);
  endtask

  task automatic t_read_single();
    idle(); as_ctl_n = 0; addr = 19'h22; adv_n = 0;   // R6 advance on load ignored
    tick(); idle();
    chk("R3 read data", 32'(rdata), 32'(ref_mem[32'h22]));
    chk("R3 read valid", 32'(rdata_en), 32'd1);
    tick();
    chk("R6 hold repeats", 32'(rdata), 32'(ref_mem[32'h22]));
  endtask

  task automatic t_linear();
    burst_ilv = 0;
    ctl_read(32'h21);
    chk("R4 start", 32'(rdata), 32'(ref_mem[32'h21]));
    for (int k = 1; k <= 4; k++) begin
      adv_n = 0; tick();
      chk("R4 linear step", 32'(rdata), 32'(ref_mem[32'h20 + ((1 + k) % 4)]));
    end
    idle();
  endtask

  task automatic t_interleave();
    burst_ilv = 1;
    ctl_read(32'h25);
    chk("R5 start", 32'(rdata), 32'(ref_mem[32'h25]));
    for (int k = 1; k <= 3; k++) begin
      adv_n = 0; tick();
      chk("R5 interleaved step", 32'(rdata), 32'(ref_mem[32'h24 + (1 ^ k)]));
    end
    idle(); burst_ilv = 0;
  endtask

  task automatic t_gw();
    idle(); as_ctl_n = 0; addr = 19'h30; wr_all_n = 0; wr_byte_n = 0;
    lane_sel_n = 2'b11; wdata = 18'h3FFFF;
    tick(); idle();
    ref_mem[32'h30] = 18'h3FFFF;
    ctl_read(32'h30);
    chk("R7 all lanes", 32'(rdata), 32'h3FFFF);
  endtask

  task automatic t_bytes();
    logic [17:0] e;
    idle(); as_ctl_n = 0; addr = 19'h30; wr_byte_n = 0; lane_sel_n = 2'b10; wdata = 18'h0;
    tick(); idle();
    ctl_read(32'h30);
    chk("R8 lane0 only", 32'(rdata), 32'h3FE00);
    idle(); as_ctl_n = 0; addr = 19'h30; wr_byte_n = 1; lane_sel_n = 2'b00; wdata = 18'h0;
    tick(); idle();
    chk("R8 no enable is read", 32'(rdata), 32'h3FE00);
    chk("R8 no enable valid", 32'(rdata_en), 32'd1);
    idle(); as_ctl_n = 0; addr = 19'h30; wr_byte_n = 0; lane_sel_n = 2'b01; wdata = 18'h15555;
    tick(); idle();
    e = (18'h3FE00 & 18'h001FF) | (18'h15555 & 18'h3FE00);
    ctl_read(32'h30);
    chk("R8 lane1 only", 32'(rdata), 32'(e));
  endtask

  task automatic t_adsp_read();
    idle(); as_proc_n = 0; addr = 19'h23; wr_all_n = 0; wdata = 18'h0;
    tick(); idle();
    chk("R9 proc start reads", 32'(rdata), 32'(ref_mem[32'h23]));
    chk("R9 proc start valid", 32'(rdata_en), 32'd1);
    ctl_read(32'h23);
    chk("R9 no write happened", 32'(rdata), 32'(ref_mem[32'h23]));
  endtask

  task automatic t_oe();
    ctl_read(32'h20);
    out_en_n = 1; #2;
    chk("R10 oe high", 32'(rdata_en), 32'd0);
    out_en_n = 0; #2;
    chk("R10 oe low", 32'(rdata_en), 32'd1);
  endtask

  task automatic t_adsp_ignored();
    burst_ilv = 0;
    ctl_read(32'h24);
    cs0_n = 1; as_proc_n = 0; adv_n = 0;
    tick(); idle();
    chk("R2 burst continues", 32'(rdata), 32'(ref_mem[32'h25]));
    chk("R2 still valid", 32'(rdata_en), 32'd1);
    cs0_n = 1; as_ctl_n = 0;
    tick(); idle();
    chk("R1 cs0 high deselects", 32'(rdata_en), 32'd0);
  endtask

  task automatic t_deselect();
    ctl_read(32'h26);
    chk("R11 first read data", 32'(rdata), 32'(ref_mem[32'h26]));
    chk("R11 first read masked", 32'(rdata_en), 32'd0);
    tick();
    chk("R11 second cycle driven", 32'(rdata_en), 32'd1);
    adv_n = 0; tick(); idle();
    chk("R11 burst driven", 32'(rdata), 32'(ref_mem[32'h27]));
    cs1 = 0; as_ctl_n = 0; tick(); idle();
    chk("R1 cs1 low deselects", 32'(rdata_en), 32'd0);
    tick();
    chk("R1 stays idle", 32'(rdata_en), 32'd0);
    cs2_n = 1; as_ctl_n = 0; tick(); idle();
    chk("R1 cs2 high deselects", 32'(rdata_en), 32'd0);
    ctl_read(32'h24);
    chk("R11 masked again", 32'(rdata_en), 32'd0);
    tick();
    chk("R11 then driven", 32'(rdata_en), 32'd1);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(); addr = '0; wdata = '0; out_en_n = 0; burst_ilv = 0; rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_fill();
    t_read_single();
    t_linear();
    t_interleave();
    t_gw();
    t_bytes();
    t_adsp_read();
    t_oe();
    t_adsp_ignored();
    t_deselect();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule